// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the command side of a small parallel NOR flash that has its array held inside the chip. Every bus write passes through a command sequencer. A write in the idle phase is read as a command byte. Later writes of a multi-cycle sequence carry a program word, an erase confirm, a buffered-write word count, buffered data or a final confirm. Bus reads are decoded according to the current mode. Depending on that mode, a read returns array bytes, the status byte, an identification word or one entry of a computed query table.

A write-protect input stops every change to the array. Instead of changing the array, the block raises error flags in the status byte. Multi-byte accesses are byte-granular and need not be aligned. A parameter picks the byte-lane order: with big-endian ordering, the byte at the lowest address sits in the most significant lane. Program and erase finish at once, so the ready flag never drops.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80, every array byte holds 0xFF, and rd_valid and rd_data are 0.
- R2: rd_valid is high in the cycle after a read request (req_valid high, req_write low) and low otherwise. rd_data changes only in the cycle after a read request.
- R3: In array-read mode a read at byte address A returns bytes A to A+BUS_BYTES-1, wrapping at the array end. With BIG_ENDIAN=1, byte A lands in the most significant lane. With BIG_ENDIAN=0, byte A lands in the least significant lane. Program writes use the same lane order.
- R4: A command byte of 0x10 or 0x40 (taken from bits 7:0 of req_wdata) arms a program. The next write stores its full word at its byte address, sets status bit 7 and leaves the block in status mode.
- R5: Command 0x20 or 0x28 arms an erase. If the next write carries 0xD0, the sector holding its address, aligned down to a SECT_BYTES boundary, is filled with 0xFF, neighbouring sectors are left unchanged, status bit 7 is set and the block enters status mode. Any other byte returns the block to array-read mode with no erase.
- R6: While wp_lock is high, the array does not change. A program or buffered data write sets status bit 4, and a confirmed erase sets status bit 5. Status bit 7 is set as in the unlocked case.
- R7: In status mode (command 0x70), and in every phase of a program, erase or buffered write, a read returns the status byte in bits 7:0 with the upper bits zero.
- R8: Command 0x50 clears the status byte to 0x00 and returns the block to array-read mode.
- R9: In identification mode (command 0x90), a read at word offset 0 returns {ID0,ID1}, a read at word offset 1 returns {ID2,ID3}, and a read at any other word offset returns 0. The word offset is the byte address divided by BUS_BYTES.
- R10: In query mode (command 0x98), a read returns the table byte at its word offset:
  - 0x10 to 0x12 hold "Q", "R", "Y".
  - 0x27 holds log2 of the array size in bytes.
  - 0x2A holds log2 of BUF_BYTES.
  - 0x2C holds 1.
  - 0x2D and 0x2E hold NUM_SECT-1, low byte first.
  - Any offset of 0x52 or above returns 0.
- R11: Command 0xE8 sets status bit 7 and starts a buffered write. The next write carries N-1 in its low bits. The following N writes each store their word at once. A final write of 0xD0 enters status mode; any other byte returns to array-read mode, and the words already written stay in the array.
- R12: In an idle-phase mode, command 0xFF, 0xF0 or any byte not listed above returns the block to array-read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*BUS_BYTES | Write data or command byte in bits 7:0 |
| wp_lock | input | 1 | Write protect; blocks array changes |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8*BUS_BYTES | Registered read data |

## Verification
The bench builds the block with 16-byte sectors, four sectors, a 2-byte bus, big-endian lane order, an 8-byte buffer and an 8-bit address. Each choice brings a different case within reach:
- The small sectors make a sector edge visible to a single unaligned read: one lane is erased and the other keeps its data.
- The big-endian order makes the lane swap observable through reads at odd addresses.
- The 8-bit address reaches query offsets past the end of the table.
- The small array lets a full post-reset sweep of every byte finish in a few dozen accesses.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_ARRAY  = 4'd0,
    M_STATUS = 4'd1,
    M_IDENT  = 4'd2,
    M_QUERY  = 4'd3,
    M_PROG   = 4'd4,
    M_ERASE  = 4'd5,
    M_BCOUNT = 4'd6,
    M_BDATA  = 4'd7,
    M_BCONF  = 4'd8
  } mode_t;

  localparam logic [7:0] CMD_PROG_A   = 8'h10;
  localparam logic [7:0] CMD_PROG_B   = 8'h40;
  localparam logic [7:0] CMD_ERASE_A  = 8'h20;
  localparam logic [7:0] CMD_ERASE_B  = 8'h28;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_BUFWR    = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;

  localparam logic [7:0] STATUS_RESET = 8'h80;
  localparam int QUERY_LEN = 'h52;

endpackage

// File: rtl/flash_query_rom.sv
module flash_query_rom #(
  parameter int ARR_BYTES  = 256,
  parameter int SECT_BYTES = 64,
  parameter int NUM_SECT   = 4,
  parameter int BUF_BYTES  = 8,
  parameter int OFF_W      = 8
) (
  input  logic [OFF_W-1:0] off,
  output logic [7:0]       q_byte
);
  import flash_cmd_pkg::*;

  localparam logic [15:0] SECT_M1 = 16'(NUM_SECT - 1);
  localparam logic [23:0] SECT_SZ = 24'(SECT_BYTES);
  localparam logic [7:0]  ARR_LOG = 8'($clog2(ARR_BYTES));
  localparam logic [7:0]  BUF_LOG = 8'($clog2(BUF_BYTES));

  always_comb begin
    q_byte = 8'h00;
    if (32'(off) < QUERY_LEN) begin
      case (32'(off))
        'h10: q_byte = 8'h51;
        'h11: q_byte = 8'h52;
        'h12: q_byte = 8'h59;
        'h13: q_byte = 8'h01;
        'h27: q_byte = ARR_LOG;
        'h2A: q_byte = BUF_LOG;
        'h2C: q_byte = 8'h01;
        'h2D: q_byte = SECT_M1[7:0];
        'h2E: q_byte = SECT_M1[15:8];
        'h2F: q_byte = SECT_SZ[15:8];
        'h30: q_byte = SECT_SZ[23:16];
        default: q_byte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int ARR_BYTES  = 256,
  parameter int SECT_BYTES = 64,
  parameter int BUS_BYTES  = 2,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(ARR_BYTES)-1:0] rd_idx,
  output logic [8*BUS_BYTES-1:0] rd_word,
  input  logic                   wr_en,
  input  logic [$clog2(ARR_BYTES)-1:0] wr_idx,
  input  logic [8*BUS_BYTES-1:0] wr_word,
  input  logic                   er_en
);
  localparam int IDX_W    = $clog2(ARR_BYTES);
  localparam int SECT_LOG = $clog2(SECT_BYTES);

  logic [7:0] mem [ARR_BYTES];

  function automatic int lane_pos(input int lane);
    return BIG_ENDIAN ? (BUS_BYTES - 1 - lane) : lane;
  endfunction

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rd_lane
    assign rd_word[8*i +: 8] = mem[rd_idx + IDX_W'(lane_pos(i))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < ARR_BYTES; b++) mem[b] <= 8'hFF;
    end else if (er_en) begin
      for (int b = 0; b < ARR_BYTES; b++) begin
        if ((IDX_W'(b) >> SECT_LOG) == (wr_idx >> SECT_LOG)) mem[b] <= 8'hFF;
      end
    end else if (wr_en) begin
      for (int i = 0; i < BUS_BYTES; i++) begin
        mem[wr_idx + IDX_W'(lane_pos(i))] <= wr_word[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BUF_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       wp_lock,
  output mode_t      mode_q,
  output logic [7:0] status_q,
  output logic       store_en,
  output logic       erase_en
);
  localparam int CNT_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign store_en = wr_stb && !wp_lock && (mode_q == M_PROG || mode_q == M_BDATA);
  assign erase_en = wr_stb && !wp_lock && mode_q == M_ERASE && wr_byte == CMD_CONFIRM;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_ARRAY;
      status_q <= STATUS_RESET;
      cnt_q    <= '0;
    end else if (wr_stb) begin
      case (mode_q)
        M_ARRAY, M_STATUS, M_IDENT, M_QUERY: begin
          case (wr_byte)
            CMD_PROG_A, CMD_PROG_B:   mode_q <= M_PROG;
            CMD_ERASE_A, CMD_ERASE_B: mode_q <= M_ERASE;
            CMD_CLR_STAT: begin
              status_q <= 8'h00;
              mode_q   <= M_ARRAY;
            end
            CMD_STATUS: mode_q <= M_STATUS;
            CMD_IDENT:  mode_q <= M_IDENT;
            CMD_QUERY:  mode_q <= M_QUERY;
            CMD_BUFWR: begin
              status_q[ST_READY] <= 1'b1;
              mode_q             <= M_BCOUNT;
            end
            default: mode_q <= M_ARRAY;
          endcase
        end
        M_PROG: begin
          if (wp_lock) status_q[ST_PROG_ERR] <= 1'b1;
          status_q[ST_READY] <= 1'b1;
          mode_q             <= M_STATUS;
        end
        M_ERASE: begin
          if (wr_byte == CMD_CONFIRM) begin
            if (wp_lock) status_q[ST_ERASE_ERR] <= 1'b1;
            status_q[ST_READY] <= 1'b1;
            mode_q             <= M_STATUS;
          end else begin
            mode_q <= M_ARRAY;
          end
        end
        M_BCOUNT: begin
          cnt_q  <= wr_byte[CNT_W-1:0];
          mode_q <= M_BDATA;
        end
        M_BDATA: begin
          if (wp_lock) status_q[ST_PROG_ERR] <= 1'b1;
          if (cnt_q == '0) mode_q <= M_BCONF;
          else             cnt_q  <= cnt_q - 1'b1;
        end
        M_BCONF: begin
          if (wr_byte == CMD_CONFIRM) begin
            status_q[ST_READY] <= 1'b1;
            mode_q             <= M_STATUS;
          end else begin
            mode_q <= M_ARRAY;
          end
        end
        default: mode_q <= M_ARRAY;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         SECT_BYTES = 64,
  parameter int         NUM_SECT   = 4,
  parameter int         BUS_BYTES  = 2,
  parameter bit         BIG_ENDIAN = 1'b0,
  parameter int         BUF_BYTES  = 8,
  parameter int         ADDR_W     = 9,
  parameter logic [7:0] ID0        = 8'h89,
  parameter logic [7:0] ID1        = 8'h18,
  parameter logic [7:0] ID2        = 8'h00,
  parameter logic [7:0] ID3        = 8'h17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [8*BUS_BYTES-1:0] req_wdata,
  input  logic                   wp_lock,
  output logic                   rd_valid,
  output logic [8*BUS_BYTES-1:0] rd_data
);
  localparam int ARR_BYTES = SECT_BYTES * NUM_SECT;
  localparam int IDX_W     = $clog2(ARR_BYTES);
  localparam int DW        = 8 * BUS_BYTES;
  localparam int BSH       = $clog2(BUS_BYTES);
  localparam int WOFF_W    = ADDR_W - BSH;
  localparam int BUF_WORDS = BUF_BYTES / BUS_BYTES;

  mode_t             mode_q;
  logic [7:0]        status_q;
  logic              store_en;
  logic              erase_en;
  logic [DW-1:0]     arr_word;
  logic [7:0]        q_byte;
  logic [WOFF_W-1:0] woff;
  logic [IDX_W-1:0]  idx;
  logic              wr_stb;
  logic              rd_stb;
  logic [DW-1:0]     rd_next;

  assign wr_stb = req_valid && req_write;
  assign rd_stb = req_valid && !req_write;
  assign woff   = req_addr[ADDR_W-1:BSH];
  assign idx    = req_addr[IDX_W-1:0];

  flash_cmd_fsm #(.BUF_WORDS(BUF_WORDS)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_byte  (req_wdata[7:0]),
    .wp_lock  (wp_lock),
    .mode_q   (mode_q),
    .status_q (status_q),
    .store_en (store_en),
    .erase_en (erase_en)
  );

  flash_byte_array #(
    .ARR_BYTES  (ARR_BYTES),
    .SECT_BYTES (SECT_BYTES),
    .BUS_BYTES  (BUS_BYTES),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_array (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (idx),
    .rd_word (arr_word),
    .wr_en   (store_en),
    .wr_idx  (idx),
    .wr_word (req_wdata),
    .er_en   (erase_en)
  );

  flash_query_rom #(
    .ARR_BYTES  (ARR_BYTES),
    .SECT_BYTES (SECT_BYTES),
    .NUM_SECT   (NUM_SECT),
    .BUF_BYTES  (BUF_BYTES),
    .OFF_W      (WOFF_W)
  ) u_query (
    .off    (woff),
    .q_byte (q_byte)
  );

  always_comb begin
    case (mode_q)
      M_ARRAY: rd_next = arr_word;
      M_IDENT: begin
        if (woff == '0)                 rd_next = DW'({ID0, ID1});
        else if (woff == WOFF_W'(1))    rd_next = DW'({ID2, ID3});
        else                            rd_next = '0;
      end
      M_QUERY: rd_next = DW'(q_byte);
      M_STATUS, M_PROG, M_ERASE, M_BCOUNT, M_BDATA, M_BCONF:
               rd_next = DW'(status_q);
      default: rd_next = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [7:0]    cmd_byte,
  input logic          wp_lock,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input mode_t         mode,
  input logic [7:0]    status
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode == M_ARRAY && status == STATUS_RESET && !rd_valid));

  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> (!rd_valid && $stable(rd_data)));

  // R4
  prog_done_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && mode == M_PROG) |=> (mode == M_STATUS && status[ST_READY]));

  // R6
  wp_erase_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && wp_lock && mode == M_ERASE && cmd_byte == CMD_CONFIRM)
      |=> (status[ST_ERASE_ERR] && status[ST_READY]));

  // R6
  wp_prog_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && wp_lock && (mode == M_PROG || mode == M_BDATA))
      |=> status[ST_PROG_ERR]);

  // R7
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && mode == M_STATUS) |=> (rd_data == DW'($past(status))));

  // R12
  abort_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (mode == M_ARRAY || mode == M_STATUS || mode == M_IDENT ||
      mode == M_QUERY) && (cmd_byte == 8'hFF || cmd_byte == 8'hF0)) |=> (mode == M_ARRAY));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .cmd_byte  (req_wdata[7:0]),
  .wp_lock   (wp_lock),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .mode      (mode_q),
  .status    (status_q)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int OP_W = 1;
  localparam int OP_R = 2;
  localparam int NVEC = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        wp_lock = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(
    .SECT_BYTES (16),
    .NUM_SECT   (4),
    .BUS_BYTES  (2),
    .BIG_ENDIAN (1'b1),
    .BUF_BYTES  (8),
    .ADDR_W     (8),
    .ID0        (8'h89),
    .ID1        (8'h18),
    .ID2        (8'h00),
    .ID3        (8'h17)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .wp_lock   (wp_lock),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // entry: {op[1:0], req[3:0], addr[7:0], data_or_expected[15:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd2, 4'd1,  8'h00, 16'hFFFF},  // R1 erased after reset
    {2'd1, 4'd4,  8'h00, 16'h0040},  // R4
    {2'd1, 4'd4,  8'h04, 16'h1234},
    {2'd2, 4'd7,  8'h04, 16'h0080},  // R7 status after program
    {2'd1, 4'd12, 8'h00, 16'h00FF},
    {2'd2, 4'd4,  8'h04, 16'h1234},  // R4 stored word
    {2'd2, 4'd3,  8'h05, 16'h34FF},  // R3 unaligned, big-endian
    {2'd2, 4'd3,  8'h03, 16'hFF12},  // R3
    {2'd1, 4'd7,  8'h00, 16'h0070},
    {2'd2, 4'd7,  8'h00, 16'h0080},  // R7
    {2'd1, 4'd8,  8'h00, 16'h0050},
    {2'd2, 4'd8,  8'h04, 16'h1234},  // R8 back to array
    {2'd1, 4'd8,  8'h00, 16'h0070},
    {2'd2, 4'd8,  8'h00, 16'h0000},  // R8 cleared
    {2'd1, 4'd9,  8'h00, 16'h0090},
    {2'd2, 4'd9,  8'h00, 16'h8918},  // R9
    {2'd2, 4'd9,  8'h02, 16'h0017},
    {2'd2, 4'd9,  8'h04, 16'h0000},
    {2'd1, 4'd10, 8'h00, 16'h0098},
    {2'd2, 4'd10, 8'h20, 16'h0051},  // R10
    {2'd2, 4'd10, 8'h22, 16'h0052},
    {2'd2, 4'd10, 8'h24, 16'h0059},
    {2'd2, 4'd10, 8'h4E, 16'h0006},
    {2'd2, 4'd10, 8'h54, 16'h0003},
    {2'd2, 4'd10, 8'h58, 16'h0001},
    {2'd2, 4'd10, 8'h5A, 16'h0003},
    {2'd2, 4'd10, 8'hA4, 16'h0000},
    {2'd1, 4'd4,  8'h00, 16'h0010},
    {2'd1, 4'd4,  8'h20, 16'hABCD},
    {2'd1, 4'd4,  8'h00, 16'h0040},
    {2'd1, 4'd4,  8'h30, 16'h5566},
    {2'd1, 4'd5,  8'h00, 16'h0028},  // R5
    {2'd1, 4'd5,  8'h23, 16'h00D0},
    {2'd2, 4'd5,  8'h00, 16'h0080},
    {2'd1, 4'd5,  8'h00, 16'h00FF},
    {2'd2, 4'd5,  8'h20, 16'hFFFF},
    {2'd2, 4'd5,  8'h2E, 16'hFFFF},
    {2'd2, 4'd5,  8'h2F, 16'hFF55},
    {2'd2, 4'd5,  8'h30, 16'h5566},
    {2'd1, 4'd5,  8'h00, 16'h0020},
    {2'd1, 4'd5,  8'h30, 16'h0011},
    {2'd2, 4'd5,  8'h30, 16'h5566},
    {2'd1, 4'd11, 8'h00, 16'h00E8},  // R11
    {2'd2, 4'd7,  8'h00, 16'h0080},
    {2'd1, 4'd11, 8'h08, 16'h0001},
    {2'd1, 4'd11, 8'h08, 16'hA1A2},
    {2'd1, 4'd11, 8'h0A, 16'hB1B2},
    {2'd1, 4'd11, 8'h00, 16'h00D0},
    {2'd2, 4'd11, 8'h00, 16'h0080},
    {2'd1, 4'd11, 8'h00, 16'h00FF},
    {2'd2, 4'd11, 8'h08, 16'hA1A2},
    {2'd2, 4'd11, 8'h0A, 16'hB1B2},
    {2'd1, 4'd11, 8'h00, 16'h00E8},
    {2'd1, 4'd11, 8'h00, 16'h0000},
    {2'd1, 4'd11, 8'h0C, 16'hC3C4},
    {2'd1, 4'd11, 8'h00, 16'h0055},
    {2'd2, 4'd11, 8'h0C, 16'hC3C4},
    {2'd1, 4'd12, 8'h00, 16'h0090},  // R12
    {2'd1, 4'd12, 8'h00, 16'h0033},
    {2'd2, 4'd12, 8'h04, 16'h1234},
    {2'd1, 4'd12, 8'h00, 16'h0070},
    {2'd1, 4'd12, 8'h00, 16'h00F0},
    {2'd2, 4'd12, 8'h04, 16'h1234}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(2, {15'd0, rd_valid}, 16'd1);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs after reset
    check(1, {15'd0, rd_valid}, 16'd0);
    check(1, rd_data, 16'h0000);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][29:28] == 2'(OP_W)) wr(VEC[k][23:16], VEC[k][15:0]);
      else if (VEC[k][29:28] == 2'(OP_R)) rd(int'(VEC[k][27:24]), VEC[k][23:16], VEC[k][15:0]);
    end

    // R2 idle cycle: no valid, data held
    rd(4, 8'h04, 16'h1234);
    @(negedge clk);
    check(2, {15'd0, rd_valid}, 16'd0);
    check(2, rd_data, 16'h1234);

    // R6 protected program
    wp_lock = 1'b1;
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0040);
    wr(8'h04, 16'h0000);
    rd(6, 8'h00, 16'h0090);
    wr(8'h00, 16'h00FF);
    rd(6, 8'h04, 16'h1234);
    // R6 protected erase
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0020);
    wr(8'h04, 16'h00D0);
    rd(6, 8'h00, 16'h00A0);
    wr(8'h00, 16'h00FF);
    rd(6, 8'h04, 16'h1234);
    // R6 protected buffered write
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h00E8);
    wr(8'h00, 16'h0000);
    wr(8'h04, 16'h0000);
    wr(8'h00, 16'h00D0);
    rd(6, 8'h00, 16'h0090);
    wr(8'h00, 16'h00FF);
    rd(6, 8'h04, 16'h1234);
    wp_lock = 1'b0;

    // R1 reset restores array, mode and status
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 64; a += 2) rd(1, 8'(a), 16'hFFFF);
    wr(8'h00, 16'h0070);
    rd(1, 8'h00, 16'h0080);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule